// File: doc/BRIEF.md
# Result Output Modifier Unit

This block sits between an ALU and the register-file write port and applies the destination modifier to a 128-bit result before it is written back. A type flag picks one of two paths.

On the float path the data is four fp32 lanes. A 2-bit float modifier either leaves each lane unchanged or applies one of three clamps. Each clamp replaces NaN with a fixed value. The clamps compare the sign, exponent and mantissa fields directly, so negative zero is treated as a negative number.

On the integer path each 32-bit lane holds a double-width result. A 2-bit integer modifier narrows each lane to 16 bits by signed saturation, unsigned saturation, or by keeping the low or high half. A shrink-mode field packs the four narrowed lanes into the lower or upper 64 bits of the destination. It can instead leave the full result unnarrowed.

An 8-bit write mask, one bit per 16-bit chunk, zeroes the disabled chunks. The result is registered with one cycle of latency.

Top module: `result_omod`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous cycle, and `out_data` is loaded one cycle after an accepted input. `out_data` holds its value while `in_valid` is low. A synchronous reset clears `out_valid`, `out_data` and `out_cfg_err` to 0.
- R2: With `in_is_float`=1, `in_fmod`=0 passes every fp32 lane (lane i at bits 32i+31..32i) unchanged, NaN included.
- R3: `in_fmod`=1 gives max(x, +0.0) per lane. Any lane with the sign bit set becomes 0x00000000; this covers -0.0, negative infinity and negative numbers. A NaN (exponent 0xFF, mantissa non-zero) becomes 0x00000000.
- R4: `in_fmod`=2 clamps each lane to [-1.0, +1.0]. A magnitude above 0x3F800000 becomes 0x3F800000 or 0xBF800000 according to its sign, and NaN becomes 0xBF800000. -0.0 passes unchanged.
- R5: `in_fmod`=3 clamps each lane to [+0.0, +1.0]. NaN and any lane with the sign bit set become 0x00000000, and values above 0x3F800000 become 0x3F800000.
- R6: With `in_is_float`=0, `in_imod`=0 narrows each 32-bit lane, read as signed, to 16 bits with signed saturation (0x7FFF / 0x8000).
- R7: `in_imod`=1 narrows each lane, read as signed, to 16 bits with unsigned saturation. Negative values give 0x0000, and values above 65535 give 0xFFFF.
- R8: `in_imod`=2 keeps bits 15..0 of each lane, and `in_imod`=3 keeps bits 31..16.
- R9: `in_shrink`=0 places narrowed lane i at bits 16i+15..16i and zeroes the upper 64 bits. `in_shrink`=1 places it at 64+16i and zeroes the lower 64 bits. `in_shrink`=2 passes the 128-bit integer result without narrowing.
- R10: For an integer input with `in_shrink`=2 and `in_imod`≠2, or with `in_shrink`=3, `out_cfg_err` is 1 in the output cycle and the data is passed unnarrowed. Otherwise `out_cfg_err` is 0.
- R11: `in_mask` bit k gates bits 16k+15..16k of the result, and a cleared bit forces that chunk to zero.
- R12: On the float path, `in_imod` and `in_shrink` have no effect on data and `out_cfg_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input result is valid |
| in_is_float | input | 1 | 1: fp32 lanes, 0: double-width integer lanes |
| in_data | input | 128 | Unmodified ALU result |
| in_fmod | input | 2 | Float modifier |
| in_imod | input | 2 | Integer narrowing modifier |
| in_shrink | input | 2 | Narrowed placement: 0 lower, 1 upper, 2 none |
| in_mask | input | 8 | Write mask, one bit per 16-bit chunk |
| out_valid | output | 1 | Registered result valid |
| out_data | output | 128 | Modified and masked destination data |
| out_cfg_err | output | 1 | Illegal integer modifier and shrink combination |

## Verification
Several properties are checked on every cycle:
- valid latency and data hold when idle;
- zeroing of every masked chunk;
- raising of the configuration error flag, and its absence on float inputs;
- non-negative results of the two zero-based clamps, and the absence of NaN or out-of-range output from the signed clamp;
- sign preservation under signed saturation.

The exact bit patterns need the bench's scenarios to show them. These include the replacement values for NaN, the treatment of -0.0 and the infinities, the saturation limits, lane order and half placement, and the passthrough when narrowing is off.

// File: rtl/omod_pkg.sv
package omod_pkg;

    localparam int          LANE_W     = 32;
    localparam logic [31:0] FP_POS_ONE = 32'h3F80_0000;
    localparam logic [31:0] FP_NEG_ONE = 32'hBF80_0000;

    typedef enum logic [1:0] {
        FMOD_PASS  = 2'd0,
        FMOD_POS   = 2'd1,
        FMOD_SNORM = 2'd2,
        FMOD_UNORM = 2'd3
    } fmod_e;

    typedef enum logic [1:0] {
        IMOD_SSAT = 2'd0,
        IMOD_USAT = 2'd1,
        IMOD_LOW  = 2'd2,
        IMOD_HIGH = 2'd3
    } imod_e;

    typedef enum logic [1:0] {
        SHR_LOWER = 2'd0,
        SHR_UPPER = 2'd1,
        SHR_NONE  = 2'd2,
        SHR_RSVD  = 2'd3
    } shrink_e;

    typedef struct packed {
        logic    is_float;
        fmod_e   fmod;
        imod_e   imod;
        shrink_e shrink;
    } ctrl_t;

    function automatic logic fp32_is_nan(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
    endfunction

    function automatic logic fp32_mag_above_one(input logic [31:0] v);
        return v[30:0] > FP_POS_ONE[30:0];
    endfunction

    function automatic logic ctrl_is_illegal(input ctrl_t c);
        return !c.is_float &&
               ((c.shrink == SHR_RSVD) ||
                ((c.shrink == SHR_NONE) && (c.imod != IMOD_LOW)));
    endfunction

endpackage

// File: rtl/omod_fp_clamp.sv
module omod_fp_clamp
    import omod_pkg::*;
(
    input  logic [LANE_W-1:0] lane_in,
    input  fmod_e             mode,
    output logic [LANE_W-1:0] lane_out
);

    logic is_nan;
    logic is_neg;
    logic too_big;

    always_comb begin
        is_nan  = fp32_is_nan(lane_in);
        is_neg  = lane_in[LANE_W-1];
        too_big = fp32_mag_above_one(lane_in);
        lane_out = lane_in;
        unique case (mode)
            FMOD_PASS: lane_out = lane_in;
            FMOD_POS: begin
                if (is_nan || is_neg) lane_out = '0;
            end
            FMOD_SNORM: begin
                if (is_nan)       lane_out = FP_NEG_ONE;
                else if (too_big) lane_out = is_neg ? FP_NEG_ONE : FP_POS_ONE;
            end
            FMOD_UNORM: begin
                if (is_nan || is_neg) lane_out = '0;
                else if (too_big)     lane_out = FP_POS_ONE;
            end
            default: lane_out = lane_in;
        endcase
    end

    always_comb begin
        // R3 R5
        nonneg_result_chk: assert (!((mode == FMOD_POS) || (mode == FMOD_UNORM)) ||
                                   (lane_out[LANE_W-1] == 1'b0))
            else $error("zero-based clamp produced a negative lane");
        // R4
        snorm_range_chk: assert ((mode != FMOD_SNORM) ||
                                 (!fp32_is_nan(lane_out) &&
                                  !fp32_mag_above_one(lane_out)))
            else $error("signed clamp produced NaN or out-of-range lane");
    end

endmodule

// File: rtl/omod_int_shrink.sv
module omod_int_shrink
    import omod_pkg::*;
#(
    parameter int WIDE_W = 32
) (
    input  logic [WIDE_W-1:0]   wide_val,
    input  imod_e               mode,
    output logic [WIDE_W/2-1:0] narrow_val
);

    localparam int NW = WIDE_W / 2;

    logic          sign_bit;
    logic          fits_signed;
    logic          fits_unsigned;
    logic [NW-1:0] s_max;
    logic [NW-1:0] s_min;

    always_comb begin
        s_max         = {1'b0, {(NW-1){1'b1}}};
        s_min         = {1'b1, {(NW-1){1'b0}}};
        sign_bit      = wide_val[WIDE_W-1];
        fits_signed   = (wide_val[WIDE_W-1:NW-1] == '0) ||
                        (wide_val[WIDE_W-1:NW-1] == '1);
        fits_unsigned = (wide_val[WIDE_W-1:NW] == '0);
        narrow_val    = wide_val[NW-1:0];
        unique case (mode)
            IMOD_SSAT: begin
                if (!fits_signed) narrow_val = sign_bit ? s_min : s_max;
            end
            IMOD_USAT: begin
                if (sign_bit)           narrow_val = '0;
                else if (!fits_unsigned) narrow_val = '1;
            end
            IMOD_LOW:  narrow_val = wide_val[NW-1:0];
            IMOD_HIGH: narrow_val = wide_val[WIDE_W-1:NW];
            default:   narrow_val = wide_val[NW-1:0];
        endcase
    end

    always_comb begin
        // R6
        ssat_sign_chk: assert ((mode != IMOD_SSAT) ||
                               (narrow_val[NW-1] == wide_val[WIDE_W-1]))
            else $error("signed saturation changed the sign");
    end

endmodule

// File: rtl/omod_assemble.sv
module omod_assemble
    import omod_pkg::*;
#(
    parameter int DATA_W  = 128,
    parameter int CHUNK_W = 16
) (
    input  logic                        is_float,
    input  shrink_e                     shrink,
    input  logic [DATA_W-1:0]           fp_res,
    input  logic [DATA_W/2-1:0]         narrow_res,
    input  logic [DATA_W-1:0]           int_raw,
    input  logic [DATA_W/CHUNK_W-1:0]   mask,
    output logic [DATA_W-1:0]           data_out
);

    localparam int HALF_W = DATA_W / 2;
    localparam int NCHUNK = DATA_W / CHUNK_W;

    logic [DATA_W-1:0] pre_mask;

    always_comb begin
        if (is_float) begin
            pre_mask = fp_res;
        end else begin
            unique case (shrink)
                SHR_LOWER: pre_mask = {{HALF_W{1'b0}}, narrow_res};
                SHR_UPPER: pre_mask = {narrow_res, {HALF_W{1'b0}}};
                default:   pre_mask = int_raw;
            endcase
        end
    end

    for (genvar k = 0; k < NCHUNK; k++) begin : g_chunk
        assign data_out[k*CHUNK_W +: CHUNK_W] =
            mask[k] ? pre_mask[k*CHUNK_W +: CHUNK_W] : '0;
    end

endmodule

// File: rtl/result_omod.sv
module result_omod
    import omod_pkg::*;
#(
    parameter int DATA_W  = 128,
    parameter int CHUNK_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic                      in_is_float,
    input  logic [DATA_W-1:0]         in_data,
    input  logic [1:0]                in_fmod,
    input  logic [1:0]                in_imod,
    input  logic [1:0]                in_shrink,
    input  logic [DATA_W/CHUNK_W-1:0] in_mask,
    output logic                      out_valid,
    output logic [DATA_W-1:0]         out_data,
    output logic                      out_cfg_err
);

    localparam int NLANE    = DATA_W / LANE_W;
    localparam int NARROW_W = LANE_W / 2;
    localparam int NCHUNK   = DATA_W / CHUNK_W;

    ctrl_t                 ctrl_c;
    logic [DATA_W-1:0]     fp_res;
    logic [DATA_W/2-1:0]   narrow_res;
    logic [DATA_W-1:0]     assembled;
    logic                  cfg_err_c;

    always_comb begin
        ctrl_c.is_float = in_is_float;
        ctrl_c.fmod     = fmod_e'(in_fmod);
        ctrl_c.imod     = imod_e'(in_imod);
        ctrl_c.shrink   = shrink_e'(in_shrink);
        cfg_err_c       = ctrl_is_illegal(ctrl_c);
    end

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        omod_fp_clamp u_fp (
            .lane_in  (in_data[i*LANE_W +: LANE_W]),
            .mode     (ctrl_c.fmod),
            .lane_out (fp_res[i*LANE_W +: LANE_W])
        );

        omod_int_shrink #(.WIDE_W(LANE_W)) u_int (
            .wide_val   (in_data[i*LANE_W +: LANE_W]),
            .mode       (ctrl_c.imod),
            .narrow_val (narrow_res[i*NARROW_W +: NARROW_W])
        );
    end

    omod_assemble #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_asm (
        .is_float   (ctrl_c.is_float),
        .shrink     (ctrl_c.shrink),
        .fp_res     (fp_res),
        .narrow_res (narrow_res),
        .int_raw    (in_data),
        .mask       (in_mask),
        .data_out   (assembled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_cfg_err <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_cfg_err <= in_valid && cfg_err_c;
            if (in_valid) out_data <= assembled;
        end
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
    // R10
    cfg_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_is_float && (in_shrink == 2'd2) && (in_imod != 2'd2))
            |=> out_cfg_err);
    // R12
    float_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_is_float) |=> !out_cfg_err);

    for (genvar k = 0; k < NCHUNK; k++) begin : g_mask_chk
        // R11
        masked_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !in_mask[k]) |=> (out_data[k*CHUNK_W +: CHUNK_W] == '0));
    end

endmodule

// File: tb/result_omod_bench.sv
module result_omod_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_is_float = 1'b0;
    logic [127:0] in_data = '0;
    logic [1:0]   in_fmod = '0;
    logic [1:0]   in_imod = '0;
    logic [1:0]   in_shrink = '0;
    logic [7:0]   in_mask = '0;
    logic         out_valid;
    logic [127:0] out_data;
    logic         out_cfg_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [127:0] exp_data_q[$];
    logic         exp_err_q[$];
    string        exp_tag_q[$];
    logic [127:0] last_exp = '0;

    always #2 clk = ~clk;

    result_omod u_result_omod (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_is_float(in_is_float),
        .in_data(in_data), .in_fmod(in_fmod), .in_imod(in_imod),
        .in_shrink(in_shrink), .in_mask(in_mask), .out_valid(out_valid),
        .out_data(out_data), .out_cfg_err(out_cfg_err)
    );

    function automatic logic [31:0] ref_fp(input logic [31:0] x, input logic [1:0] m);
        logic nan;
        nan = (x[30:23] == 8'hFF) && (x[22:0] != 0);
        case (m)
            2'd0: return x;
            2'd1: return (nan || x[31]) ? 32'h0 : x;
            2'd2: begin
                if (nan) return 32'hBF800000;
                if (x[30:0] > 31'h3F800000) return x[31] ? 32'hBF800000 : 32'h3F800000;
                return x;
            end
            default: begin
                if (nan || x[31]) return 32'h0;
                if (x > 32'h3F800000) return 32'h3F800000;
                return x;
            end
        endcase
    endfunction

    function automatic logic [15:0] ref_int(input logic [31:0] v, input logic [1:0] m);
        longint s;
        s = longint'($signed(v));
        case (m)
            2'd0: begin
                if (s > 32767)  return 16'h7FFF;
                if (s < -32768) return 16'h8000;
                return v[15:0];
            end
            2'd1: begin
                if (s < 0)     return 16'h0000;
                if (s > 65535) return 16'hFFFF;
                return v[15:0];
            end
            2'd2: return v[15:0];
            default: return v[31:16];
        endcase
    endfunction

    function automatic logic [127:0] ref_out(input logic f, input logic [127:0] d,
            input logic [1:0] fm, input logic [1:0] im, input logic [1:0] sh,
            input logic [7:0] mk);
        logic [127:0] r;
        logic [63:0]  nar;
        if (f) begin
            for (int i = 0; i < 4; i++) r[i*32 +: 32] = ref_fp(d[i*32 +: 32], fm);
        end else if (sh >= 2'd2) begin
            r = d;
        end else begin
            for (int i = 0; i < 4; i++) nar[i*16 +: 16] = ref_int(d[i*32 +: 32], im);
            r = (sh == 2'd0) ? {64'h0, nar} : {nar, 64'h0};
        end
        for (int k = 0; k < 8; k++) if (!mk[k]) r[k*16 +: 16] = 16'h0;
        return r;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic f, input logic [127:0] d,
            input logic [1:0] fm, input logic [1:0] im, input logic [1:0] sh,
            input logic [7:0] mk);
        @(negedge clk);
        in_valid = 1'b1; in_is_float = f; in_data = d;
        in_fmod = fm; in_imod = im; in_shrink = sh; in_mask = mk;
        last_exp = ref_out(f, d, fm, im, sh, mk);
        exp_data_q.push_back(last_exp);
        exp_err_q.push_back(!f && ((sh == 2'd3) || (sh == 2'd2 && im != 2'd2)));
        exp_tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_data_q.size() == 0) begin
                check("R1 unexpected output", {127'h0, out_valid}, 128'h0);
            end else begin
                string t;
                logic [127:0] ed;
                logic ee;
                t  = exp_tag_q.pop_front();
                ed = exp_data_q.pop_front();
                ee = exp_err_q.pop_front();
                check(t, out_data, ed);
                check({t, " R10 err"}, {127'h0, out_cfg_err}, {127'h0, ee});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    localparam logic [127:0] FSET_A = {32'hBFC00000, 32'h3FC00000, 32'h80000000, 32'h7FC00001};
    localparam logic [127:0] FSET_B = {32'hFF800000, 32'h7F800000, 32'hBF000000, 32'h3F000000};
    localparam logic [127:0] FSET_C = {32'hFFC00000, 32'h00000001, 32'hBF800000, 32'h3F800000};
    localparam logic [127:0] ISET_A = {32'h00007FFF, 32'hFFFE0000, 32'hFFFF8000, 32'h00012345};
    localparam logic [127:0] ISET_B = {32'h00008000, 32'hFFFFFFFF, 32'h00010000, 32'h0000FFFF};

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset valid", {127'h0, out_valid}, 128'h0);
        check("R1 reset data", out_data, 128'h0);
        check("R1 reset err", {127'h0, out_cfg_err}, 128'h0);
        rst = 1'b0;

        // R2 R3 R4 R5 float modes; R12: imod/shrink set to integer-looking values
        for (int m = 0; m < 4; m++) begin
            string t;
            t = (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
            drive(t, 1'b1, FSET_A, 2'(m), 2'd0, 2'd0, 8'hFF);
            drive(t, 1'b1, FSET_B, 2'(m), 2'd1, 2'd1, 8'hFF);
            drive(t, 1'b1, FSET_C, 2'(m), 2'd3, 2'd3, 8'hFF);
        end
        drive("R12 float ignores imod shrink", 1'b1, FSET_A, 2'd2, 2'd0, 2'd2, 8'hFF);

        // R6 R7 R8 R9 integer narrowing and placement
        for (int im = 0; im < 4; im++) begin
            for (int sh = 0; sh < 2; sh++) begin
                string t;
                t = (im == 0) ? "R6 R9" : (im == 1) ? "R7 R9" : "R8 R9";
                drive(t, 1'b0, ISET_A, 2'd0, 2'(im), 2'(sh), 8'hFF);
                drive(t, 1'b0, ISET_B, 2'd0, 2'(im), 2'(sh), 8'hFF);
            end
        end
        drive("R9 no narrowing", 1'b0, ISET_A, 2'd0, 2'd2, 2'd2, 8'hFF);

        // R10 illegal combinations
        drive("R10 ssat without shrink", 1'b0, ISET_B, 2'd0, 2'd0, 2'd2, 8'hFF);
        drive("R10 reserved shrink", 1'b0, ISET_A, 2'd0, 2'd3, 2'd3, 8'hFF);

        // R11 write mask
        drive("R11 mask none", 1'b0, ISET_A, 2'd0, 2'd2, 2'd2, 8'h00);
        drive("R11 mask A5", 1'b0, ISET_B, 2'd0, 2'd2, 2'd2, 8'hA5);
        drive("R11 mask on float", 1'b1, FSET_B, 2'd3, 2'd0, 2'd0, 8'h5A);
        drive("R11 mask on upper placement", 1'b0, ISET_A, 2'd0, 2'd0, 2'd1, 8'h3C);

        // mixed back-to-back traffic
        for (int n = 0; n < 300; n++) begin
            logic [127:0] d;
            d = {$urandom, $urandom, $urandom, $urandom};
            if (n % 3 == 0) d[31:0] = 32'h7F800000 | 32'($urandom % 4);
            drive("mixed", 1'($urandom), d, 2'($urandom), 2'($urandom),
                  2'($urandom % 3), 8'($urandom));
        end

        idle(4);
        // R1 output holds while idle
        check("R1 idle valid", {127'h0, out_valid}, 128'h0);
        check("R1 idle hold", out_data, last_exp);
        check("R1 queue drained", 128'(exp_data_q.size()), 128'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule